// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port Controller with Per-Bit Open-Drain

This block controls one general-purpose I/O port of a small microcontroller. Every pin bit carries three control bits: a direction bit, an output latch bit and an open-drain enable bit. Combining the three, the block decides for each pad whether it drives high, drives low or floats. It also decides what a CPU read of the data address returns. In push-pull output mode a read returns the latch. In input mode and open-drain mode a read returns the synchronized pin level, so a wired-AND bus line can be observed.

Software accesses the port through a small register bus. A write strobe, a two-bit address, write data and combinational read data are enough. The pad side is per-pin: an output value, an output enable and the raw input sample. Two inputs override all drive. The first is a stop input that parks the port. The second is a fault input from a clock-failure detector. While either input is high, every output enable is low, and the register contents are left intact.

Per-bit behaviour is written as a three-state mode selection: input, push-pull and open-drain. A `unique case` resolves each mode. Input samples pass through a two-stage synchronizer before they reach the read path.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction, latch and open-drain registers are all 0, so every pin is an input and `pad_oe` is all 0.
- R2: A write with `bus_wr`=1 updates the register selected by `bus_addr` on the next rising clock edge. The address encoding is: 0 = direction, 1 = data latch, 2 = open-drain enable. Reading address 0 returns the stored direction bits and reading address 2 returns the stored open-drain bits. Address 3 reads as 0, and a write to address 3 changes no register.
- R3: A bit with direction 0 (input mode) has `pad_oe`=0. Its bit in a data read (address 1) is the synchronized pin level.
- R4: A bit with direction 1 and open-drain 0 (push-pull) has `pad_oe`=1 and `pad_out` equal to its latch bit. Its data-read bit is the latch, not the pin.
- R5: A bit with direction 1 and open-drain 1 drives low (`pad_oe`=1, `pad_out`=0) when its latch bit is 0. It floats (`pad_oe`=0) when its latch bit is 1. Its data-read bit is the synchronized pin level.
- R6: While `stop_i` is 1, every `pad_oe` bit is 0. The registers keep their values, and drive resumes unchanged when `stop_i` returns to 0.
- R7: While `osc_fault_i` is 1, every `pad_oe` bit is 0 whatever the register contents. The registers are retained.
- R8: A change on `pad_in` appears in data-read bits of non-push-pull pins after exactly two rising clock edges, not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 direction, 1 data, 2 open-drain) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| stop_i | input | 1 | Forces all output enables off |
| osc_fault_i | input | 1 | Clock-failure fault; forces all pins to high impedance |
| pad_in | input | 8 | Raw pin input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable (1 = drive) |

## Verification
The three per-bit modes are exercised with random direction, latch, open-drain and pin patterns. Every port has all three modes mixed across its bits. This separates a read path that picks the latch from one that picks the pin, and it separates open-drain float from push-pull high. Directed patterns set a pin level that disagrees with the latch: all-ones against all-zeros, and alternating bits. That mismatch shows which source each mode reads back. A directed pin step counts edges to pin the synchronizer depth at exactly two. Stop and fault are each raised over a port that is actively driving and then released. This shows both the forced float and the unchanged drive afterwards.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 2'd0,
        REG_DATA = 2'd1,
        REG_ODE  = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

    typedef enum logic [1:0] {
        PM_INPUT     = 2'd0,
        PM_PUSHPULL  = 2'd1,
        PM_OPENDRAIN = 2'd2
    } pin_mode_e;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WIDTH-1:0]     wr_data,
    output logic [WIDTH-1:0]     dir_q,
    output logic [WIDTH-1:0]     dat_q,
    output logic [WIDTH-1:0]     ode_q
);

    gpio_reg_e sel;
    logic      we_dir;
    logic      we_dat;
    logic      we_ode;

    always_comb begin
        sel    = gpio_reg_e'(wr_addr);
        we_dir = 1'b0;
        we_dat = 1'b0;
        we_ode = 1'b0;
        unique case (sel)
            REG_DIR:  we_dir = wr_en;
            REG_DATA: we_dat = wr_en;
            REG_ODE:  we_ode = wr_en;
            REG_NONE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
            ode_q <= '0;
        end else begin
            if (we_dir) dir_q <= wr_data;
            if (we_dat) dat_q <= wr_data;
            if (we_ode) ode_q <= wr_data;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
(
    input  logic dir_b,
    input  logic dat_b,
    input  logic ode_b,
    input  logic pin_s,
    input  logic force_hiz,
    output logic out_b,
    output logic oe_b,
    output logic rd_b
);

    pin_mode_e mode;
    logic      oe_raw;

    always_comb begin
        if (!dir_b)     mode = PM_INPUT;
        else if (ode_b) mode = PM_OPENDRAIN;
        else            mode = PM_PUSHPULL;
    end

    always_comb begin
        oe_raw = 1'b0;
        out_b  = 1'b0;
        rd_b   = pin_s;
        unique case (mode)
            PM_INPUT: begin
                oe_raw = 1'b0;
                rd_b   = pin_s;
            end
            PM_PUSHPULL: begin
                oe_raw = 1'b1;
                out_b  = dat_b;
                rd_b   = dat_b;
            end
            PM_OPENDRAIN: begin
                oe_raw = ~dat_b;
                out_b  = 1'b0;
                rd_b   = pin_s;
            end
            default: ;
        endcase
    end

    assign oe_b = oe_raw & ~force_hiz;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic                 stop_i,
    input  logic                 osc_fault_i,
    input  logic [WIDTH-1:0]     pad_in,
    output logic [WIDTH-1:0]     pad_out,
    output logic [WIDTH-1:0]     pad_oe
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] ode_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] data_view;
    logic             force_hiz;

    assign force_hiz = stop_i | osc_fault_i;

    gpio_regfile #(.WIDTH(WIDTH)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .ode_q   (ode_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        gpio_pin_ctrl pin_i (
            .dir_b     (dir_q[b]),
            .dat_b     (dat_q[b]),
            .ode_b     (ode_q[b]),
            .pin_s     (pin_sync[b]),
            .force_hiz (force_hiz),
            .out_b     (pad_out[b]),
            .oe_b      (pad_oe[b]),
            .rd_b      (data_view[b])
        );
    end

    always_comb begin
        unique case (gpio_reg_e'(bus_addr))
            REG_DIR:  bus_rdata = dir_q;
            REG_DATA: bus_rdata = data_view;
            REG_ODE:  bus_rdata = ode_q;
            REG_NONE: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              stop_i,
    input logic              osc_fault_i,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  dat_q,
    input logic [WIDTH-1:0]  ode_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && dat_q == '0 && ode_q == '0 && pad_oe == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> dir_q == $past(bus_wdata));

    p_hole_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q)
                                          && ode_q == $past(ode_q)));

    p_input_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    p_pushpull_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ dat_q) & pad_oe & ~ode_q) == '0);

    p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ode_q & (pad_out | dat_q)) == '0);

    p_stop_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> pad_oe == '0);

    p_fault_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fault_i |-> pad_oe == '0);

    p_fault_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_fault_i && !bus_wr) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q)
                                      && ode_q == $past(ode_q)));

endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .stop_i      (stop_i),
    .osc_fault_i (osc_fault_i),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .dir_q       (dir_q),
    .dat_q       (dat_q),
    .ode_q       (ode_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;

    localparam int unsigned W       = 8;
    localparam time         CLK_PER = 10ns;
    localparam int unsigned MAX_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         stop_i = 1'b0;
    logic         osc_fault_i = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_dat = '0;
    logic [W-1:0] m_ode = '0;

    always #(CLK_PER/2) clk = ~clk;

    gpio_port_ctrl #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_i(stop_i),
        .osc_fault_i(osc_fault_i), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [W-1:0] f_oe(logic [W-1:0] d, logic [W-1:0] l,
                                          logic [W-1:0] o, logic hiz);
        return hiz ? '0 : (d & (~o | ~l));
    endfunction

    function automatic logic [W-1:0] f_rd(logic [W-1:0] d, logic [W-1:0] l,
                                          logic [W-1:0] o, logic [W-1:0] pin);
        logic [W-1:0] pp;
        pp = d & ~o;
        return (pp & l) | (~pp & pin);
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_dir = d;
        if (a == 2'd1) m_dat = d;
        if (a == 2'd2) m_ode = d;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [W-1:0] v;
        logic [W-1:0] eoe;
        eoe = f_oe(m_dir, m_dat, m_ode, stop_i | osc_fault_i);
        check({tag, " oe"}, pad_oe, eoe);
        check({tag, " out"}, pad_out & eoe, m_dat & eoe);
        rd(2'd0, v); check({tag, " dir rd"}, v, m_dir);
        rd(2'd1, v); check({tag, " data rd"}, v, f_rd(m_dir, m_dat, m_ode, pad_in));
        rd(2'd2, v); check({tag, " ode rd"}, v, m_ode);
    endtask

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe after reset", pad_oe, '0);
        rd(2'd0, v); check("R1 dir after reset", v, '0);
        rd(2'd2, v); check("R1 ode after reset", v, '0);
        rd(2'd3, v); check("R2 hole reads 0", v, '0);

        // R8: exactly two edges of latency on input sampling
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk); rd(2'd1, v); check("R8 one edge still old", v, 8'h00);
        @(negedge clk); rd(2'd1, v); check("R8 two edges new", v, 8'hA5);

        // R4: push-pull drives latch, reads latch against opposite pin
        pad_in = 8'hFF;
        wr(2'd1, 8'h00); wr(2'd0, 8'hFF); settle();
        check_all("R4 pushpull low vs pin high");
        rd(2'd1, v); check("R4 read is latch", v, 8'h00);

        // R5: open-drain, latch alternating, pin low
        pad_in = 8'h00;
        wr(2'd2, 8'hFF); wr(2'd1, 8'h55); settle();
        check_all("R5 opendrain");
        check("R5 drive low only on 0 latch", pad_oe, 8'hAA);
        rd(2'd1, v); check("R5 read is pin", v, 8'h00);

        // R3: input mode with latch set
        wr(2'd0, 8'h00); pad_in = 8'h3C; settle();
        check_all("R3 input");

        // R2: write to hole changes nothing
        wr(2'd0, 8'hF0); wr(2'd2, 8'h0F); wr(2'd3, 8'hFF); settle();
        check_all("R2 after hole write");

        // R6: stop floats a driving port, then drive resumes
        wr(2'd2, 8'h00); wr(2'd0, 8'hFF);
        @(negedge clk); stop_i = 1'b1; #1;
        check("R6 stop forces float", pad_oe, '0);
        check_all("R6 regs kept under stop");
        stop_i = 1'b0; #1;
        check("R6 drive resumes", pad_oe, 8'hFF);

        // R7: fault floats port, regs retained
        @(negedge clk); osc_fault_i = 1'b1; #1;
        check("R7 fault forces float", pad_oe, '0);
        settle();
        check_all("R7 regs kept under fault");
        osc_fault_i = 1'b0; #1;
        check("R7 drive resumes", pad_oe, 8'hFF);

        // Random mixed patterns covering R2..R7
        for (int i = 0; i < 200; i++) begin
            logic [1:0] a;
            a = 2'($urandom_range(0, 3));
            wr(a, W'($urandom()));
            pad_in      = W'($urandom());
            stop_i      = ($urandom_range(0, 7) == 0);
            osc_fault_i = ($urandom_range(0, 7) == 0);
            settle();
            check_all("R2-mix random");
            rd(2'd3, v); check("R2 random hole", v, '0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule